// File: doc/BRIEF.md
# Guard Soak Qualification Timer

This block decides when a clock reference has misbehaved often enough to be disqualified, and when it has behaved long enough to be trusted again. It works as a leaky integrator: a level counter climbs by one on every tick strobe that carries an unmasked failure event from either the per-cycle period check or the coarse frequency check, and it drains slowly on ticks without failures. The drain rate is the climb rate divided by a programmable multiplier n, set by a fractional prescaler.

A sticky failure flag sets when the level reaches the programmed disqualification time D (the upper threshold) and clears only when the level drains back to zero (the lower threshold). Under continuous failures, disqualification takes D ticks. From full, requalification takes n times D clean ticks. After reset the level starts full with the flag raised, so a newly attached reference must soak clean before it is used. The reference monitors that produce the events, and the selection logic that consumes the flag, sit outside the block.

Top module: `gst_soak_timer`

## Requirements
- R1: After reset `gst_fail` is 1. The level starts at or above D, so with no failures it clears after exactly n×D ticks.
- R2: A tick with an unmasked failure raises the level by one, saturating at D. Starting from an empty level with continuous failures, `gst_fail` rises on exactly the D-th such tick.
- R3: On ticks without failures, the level drops by one on every n-th consecutive clean tick. Any failure tick restarts the count of clean ticks.
- R4: Hysteresis: `gst_fail` sets only when the level reaches D and clears only when it reaches zero. Between those points it holds its value.
- R5: A failure input whose mask bit is 1 has no effect. Mask 0 means the input is used.
- R6: Nothing changes on cycles where `tick` is 0, whatever the event inputs do.
- R7: A `dq_time` of 0 behaves as 1, and a `q_mult` of 0 behaves as 1.
- R8: If `dq_time` is lowered below the current level, the next tick first clamps the level to the new D and then applies that tick's rise or drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle integration strobe |
| scm_event | input | 1 | Per-cycle period check failure |
| cfm_event | input | 1 | Coarse frequency check failure |
| scm_mask | input | 1 | 1 = ignore `scm_event` |
| cfm_mask | input | 1 | 1 = ignore `cfm_event` |
| dq_time | input | TW | Disqualification time D, in ticks |
| q_mult | input | NW | Qualification multiplier n |
| gst_fail | output | 1 | Sticky guard-soak failure flag |

## Verification
The bench builds the block with TW=6 and NW=3. These widths keep D and n small, so full disqualify and requalify cycles, the saturated state after reset, and the clamp after D is lowered are all reached within a few dozen ticks. A behavioural model of the level, the clean-tick count and the flag is compared with `gst_fail` on every clock. This holds through directed timing cases and a long run in which D, n, the masks, the events and the tick are all randomised.

// File: rtl/gst_pkg.sv
package gst_pkg;
  // number of failure sources feeding the integrator
  localparam int unsigned GST_NSRC = 2;
  localparam int unsigned GST_SRC_SCM = 0;
  localparam int unsigned GST_SRC_CFM = 1;

  // per-tick action on the level counter
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,  // no tick
    OP_SOAK  = 2'd1,  // clean tick, no drain step yet
    OP_RISE  = 2'd2,  // failure tick
    OP_DECAY = 2'd3   // clean tick that drains one step
  } gst_op_e;
endpackage

// File: rtl/gst_event_merge.sv
module gst_event_merge #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] mask,
  output logic            any_fail
);
  logic [NSRC-1:0] live;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign live[g] = evt[g] & ~mask[g];
  end

  assign any_fail = |live;
endmodule

// File: rtl/gst_decay_prescaler.sv
module gst_decay_prescaler
  import gst_pkg::*;
#(
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          any_fail,
  input  logic [NW-1:0] n_eff,
  output gst_op_e       op
);
  logic [NW-1:0] pre_q, pre_d, nm1;

  assign nm1 = n_eff - NW'(1);

  always_comb begin
    op    = OP_IDLE;
    pre_d = pre_q;
    if (tick) begin
      if (any_fail) begin
        op    = OP_RISE;
        pre_d = '0;
      end else if (pre_q >= nm1) begin
        op    = OP_DECAY;
        pre_d = '0;
      end else begin
        op    = OP_SOAK;
        pre_d = pre_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= pre_d;
    end
  end

  AST_FAIL_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && any_fail) |=> (pre_q == '0)); // R3
  AST_COUNT_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_fail) |=> (pre_q < $past(n_eff))); // R3
endmodule

// File: rtl/gst_level_accum.sv
module gst_level_accum
  import gst_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gst_op_e       op,
  input  logic [TW-1:0] lim,
  output logic          flag
);
  logic [TW-1:0] level_q, level_d, base;
  logic          flag_q, flag_d;

  always_comb begin
    base    = (level_q > lim) ? lim : level_q;
    level_d = level_q;
    flag_d  = flag_q;
    case (op)
      OP_RISE: begin
        level_d = (base < lim) ? base + TW'(1) : lim;
        if (level_d == lim) flag_d = 1'b1;
      end
      OP_DECAY: begin
        level_d = (base != '0) ? base - TW'(1) : base;
        if (level_d == '0) flag_d = 1'b0;
      end
      OP_SOAK: level_d = base;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '1;
      flag_q  <= 1'b1;
    end else if (op != OP_IDLE) begin
      level_q <= level_d;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_LEVEL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_IDLE) |=> (level_q <= $past(lim))); // R8
  AST_SET_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (level_q == $past(lim))); // R4
  AST_CLEAR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> (level_q == '0)); // R4
  AST_RISE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RISE && level_q < lim) |=> (level_q == $past(level_q) + TW'(1))); // R2
endmodule

// File: rtl/gst_soak_timer.sv
module gst_soak_timer
  import gst_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          scm_event,
  input  logic          cfm_event,
  input  logic          scm_mask,
  input  logic          cfm_mask,
  input  logic [TW-1:0] dq_time,
  input  logic [NW-1:0] q_mult,
  output logic          gst_fail
);
  logic [GST_NSRC-1:0] evt_vec, mask_vec;
  logic [TW-1:0]       lim_eff;
  logic [NW-1:0]       n_eff;
  logic                any_fail;
  gst_op_e             op;

  assign evt_vec[GST_SRC_SCM]  = scm_event;
  assign evt_vec[GST_SRC_CFM]  = cfm_event;
  assign mask_vec[GST_SRC_SCM] = scm_mask;
  assign mask_vec[GST_SRC_CFM] = cfm_mask;

  // zero programmed values fall back to one
  assign lim_eff = (dq_time == '0) ? TW'(1) : dq_time;
  assign n_eff   = (q_mult == '0) ? NW'(1) : q_mult;

  gst_event_merge #(.NSRC(GST_NSRC)) i_merge (
    .evt      (evt_vec),
    .mask     (mask_vec),
    .any_fail (any_fail)
  );

  gst_decay_prescaler #(.NW(NW)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .any_fail (any_fail),
    .n_eff    (n_eff),
    .op       (op)
  );

  gst_level_accum #(.TW(TW)) i_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .lim   (lim_eff),
    .flag  (gst_fail)
  );

  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gst_fail)); // R6
  AST_MASKED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(scm_event && !scm_mask) && !(cfm_event && !cfm_mask)) |=> !$rose(gst_fail)); // R5
endmodule

// File: tb/test_gst_soak_timer.sv
module test_gst_soak_timer;
  localparam int TW = 6;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, scm_event, cfm_event, scm_mask, cfm_mask;
  logic [TW-1:0] dq_time;
  logic [NW-1:0] q_mult;
  logic gst_fail;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  int m_level, m_pre;
  bit m_flag;

  always #5 clk = ~clk;

  gst_soak_timer #(.TW(TW), .NW(NW)) i_gst_soak_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .scm_event(scm_event), .cfm_event(cfm_event),
    .scm_mask(scm_mask), .cfm_mask(cfm_mask),
    .dq_time(dq_time), .q_mult(q_mult), .gst_fail(gst_fail)
  );

  task automatic check(string req, bit exp);
    checks++;
    if (gst_fail !== exp) begin
      failures++;
      $display("FAIL %s: gst_fail actual=%0b expected=%0b at %0t", req, gst_fail, exp, $time);
    end
  endtask

  task automatic model_step();
    int d, n, base;
    bit f;
    if (!tick) return;
    d = (dq_time == 0) ? 1 : int'(dq_time);
    n = (q_mult == 0) ? 1 : int'(q_mult);
    f = (scm_event && !scm_mask) || (cfm_event && !cfm_mask);
    base = (m_level > d) ? d : m_level;
    if (f) begin
      m_level = (base < d) ? base + 1 : d;
      m_pre = 0;
      if (m_level == d) m_flag = 1;
    end else if (m_pre >= n - 1) begin
      m_pre = 0;
      m_level = (base > 0) ? base - 1 : 0;
      if (m_level == 0) m_flag = 0;
    end else begin
      m_pre++;
      m_level = base;
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic run(string req, bit t, bit s, bit c);
    tick = t; scm_event = s; cfm_event = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, m_flag);
  endtask

  task automatic run_n(string req, int k, bit t, bit s, bit c);
    for (int i = 0; i < k; i++) run(req, t, s, c);
  endtask

  initial begin
    rst_n = 0; tick = 0; scm_event = 0; cfm_event = 0;
    scm_mask = 0; cfm_mask = 0; dq_time = 5; q_mult = 3;
    m_level = (1 << TW) - 1; m_pre = 0; m_flag = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1);
    rst_n = 1;
    @(negedge clk);

    // R1/R3: clear after exactly n*D = 15 clean ticks
    run_n("R1", 14, 1, 0, 0);
    check("R1 before 15", 1'b1);
    run("R3", 1, 0, 0);
    check("R1 at 15", 1'b0);

    // R6: events without tick
    run_n("R6", 10, 0, 1, 1);
    check("R6", 1'b0);

    // R5: masked events with ticks
    scm_mask = 1; cfm_mask = 1;
    run_n("R5", 10, 1, 1, 1);
    check("R5 both masked", 1'b0);
    scm_mask = 1; cfm_mask = 0;
    run_n("R5", 4, 1, 1, 0);
    check("R5 scm masked", 1'b0);
    scm_mask = 0; cfm_mask = 0;
    run_n("R3", 12, 1, 0, 0);

    // R2: sets on exactly the D-th failure tick, saturates
    run_n("R2", 4, 1, 0, 1);
    check("R2 after 4", 1'b0);
    run("R2", 1, 0, 1);
    check("R2 at 5", 1'b1);
    run_n("R2", 3, 1, 1, 0);
    run_n("R2", 14, 1, 0, 0);
    check("R2 saturated 14", 1'b1);
    run("R2", 1, 0, 0);
    check("R2 saturated 15", 1'b0);

    // R4/R3: partial rise then drain with interleaved failures
    run_n("R4", 3, 1, 1, 0);
    run_n("R4", 2, 1, 0, 0);
    run("R3", 1, 1, 0);
    run_n("R3", 2, 1, 0, 0);
    run_n("R4", 2, 1, 1, 0);
    check("R4 rise after restart", 1'b1);
    run_n("R4", 8, 1, 0, 0);
    run("R4", 1, 0, 1);
    check("R4 hold mid-level", 1'b1);
    run_n("R4", 40, 1, 0, 0);
    check("R4 drained", 1'b0);

    // R7: zero programming means one
    dq_time = 0; q_mult = 0;
    run("R7", 1, 1, 0);
    check("R7 set", 1'b1);
    run("R7", 1, 0, 0);
    check("R7 clear", 1'b0);

    // R8: lower D below current level
    dq_time = 6; q_mult = 1;
    run_n("R8", 6, 1, 1, 0);
    check("R8 full", 1'b1);
    dq_time = 3;
    run_n("R8", 2, 1, 0, 0);
    check("R8 after 2", 1'b1);
    run("R8", 1, 0, 0);
    check("R8 after 3", 1'b0);

    // randomised run, model compared every clock
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        dq_time = TW'($urandom_range(0, 7));
        q_mult = NW'($urandom_range(0, 4));
      end
      scm_mask = ($urandom_range(0, 7) == 0);
      cfm_mask = ($urandom_range(0, 7) == 0);
      run("R3 R4 random", ($urandom_range(0, 3) != 0),
          ($urandom_range(0, 4) == 0), ($urandom_range(0, 5) == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule